// File: doc/BRIEF.md
# Inbound Address Window Filter

This block decides whether a memory request arriving from the link side may reach system memory. Each request address is compared against a set of programmable start/limit windows (two by default). A single mode bit sets what a hit means. In inclusive mode a request passes only when it lands in at least one window. In exclusive mode a request passes only when it lands in none. Window bounds have no alignment rule: any byte address can be a start or a limit. A window whose start is above its limit can never be hit, so writing all ones to the start and zero to the limit switches that window off.

Software sets the windows through a plain write port. In typical root-port use, window 0 spans the whole local memory, window 1 is switched off, and the mode is inclusive. Requests enter on a valid/ready channel. The verdict leaves on a valid/ready channel one clock later. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output stage is empty or its content is being taken in the same cycle (`res_ready` high). While `res_valid` is high and `res_ready` is low, the verdict is held unchanged and no new request is taken.

Top module: `inbound_window_filter`

## Requirements
- R1: After reset every window is switched off (start all ones, limit zero), the mode is inclusive, `res_valid` is low and `req_ready` is high, so every request is rejected (`res_pass`=0).
- R2: An address hits a window when start <= address <= limit. Both comparisons are unsigned and both bounds are inclusive, at any byte alignment.
- R3: With control bit 1 clear (inclusive), `res_pass` is 1 exactly when the address hits at least one window.
- R4: With control bit 1 set (exclusive), `res_pass` is 1 exactly when the address hits no window.
- R5: A window whose start is greater than its limit is never hit. It changes no verdict in either mode.
- R6: The write port decodes `cfg_addr` as follows: 0 = window 0 start, 1 = window 0 limit, 2 = window 1 start, 3 = window 1 limit, 4 = control. Only bit 1 of the control word is kept. Writes to addresses 5 to 7 change nothing.
- R7: A request accepted on one rising edge produces `res_valid`=1 with its verdict on `res_pass` after that edge. With `res_ready` high, `res_valid` falls one cycle later unless another request is accepted.
- R8: While `res_valid`=1 and `res_ready`=0, `res_pass` stays stable, `res_valid` stays high and `req_ready` is low. When `res_ready` rises, a waiting request is accepted on the next edge.
- R9: A request accepted on the same edge as a configuration write is judged with the settings held before that write.
- R10: The windows are independent. In inclusive mode a hit in either window passes, and a hit in an overlapping pair counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select (see R6) |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Filter can take a request this cycle |
| req_addr | input | 32 | Inbound request address |
| res_valid | output | 1 | Verdict valid |
| res_ready | input | 1 | Downstream takes the verdict |
| res_pass | output | 1 | 1 = request may pass, 0 = rejected |

## Verification
Addresses are placed one below, on, and one above each bound of a page-aligned window and of a three-byte window at odd alignment. These points separate an inclusive bound from an exclusive one and a signed compare from an unsigned one. The same addresses are then replayed in exclusive mode, with a window inverted, and with both windows switched off; this shows that the mode inverts the hit and that an inverted window never counts. Back-pressure runs hold a verdict for several cycles while a different request waits. A write placed on the same edge as a request shows that the old settings judge that request. The full-range window probes address zero and all ones.

// File: rtl/iwf_pkg.sv
package iwf_pkg;
  // position of the mode bit inside the control word
  localparam int MODE_BIT = 1;

  // verdict: inclusive passes on a hit, exclusive passes on a miss
  function automatic logic verdict(input logic any_hit, input logic excl);
    return excl ? ~any_hit : any_hit;
  endfunction
endpackage

// File: rtl/iwf_regs.sv
module iwf_regs #(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 2,
  parameter int CFG_AW  = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [CFG_AW-1:0]                cfg_addr,
  input  logic [ADDR_W-1:0]                cfg_wdata,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   win_start,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   win_limit,
  output logic                             mode_excl
);
  import iwf_pkg::*;

  localparam logic [CFG_AW-1:0] CTRL_IDX = CFG_AW'(2 * NUM_WIN);

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_start[i] <= '1;
        win_limit[i] <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == CFG_AW'(2 * i))     win_start[i] <= cfg_wdata;
        if (cfg_addr == CFG_AW'(2 * i + 1)) win_limit[i] <= cfg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              mode_excl <= 1'b0;
    else if (cfg_we && cfg_addr == CTRL_IDX) mode_excl <= cfg_wdata[MODE_BIT];
  end

  // R6
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == CTRL_IDX) |=> (mode_excl == $past(cfg_wdata[MODE_BIT])));

  // R6
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr > CTRL_IDX) |=>
      ($stable(mode_excl) && $stable(win_start) && $stable(win_limit)));
endmodule

// File: rtl/iwf_match.sv
module iwf_match #(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]   win_start,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]   win_limit,
  output logic                             any_hit
);
  logic [NUM_WIN-1:0] hit;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    logic above_start, below_limit;
    assign above_start = (addr >= win_start[i]);
    assign below_limit = (addr <= win_limit[i]);
    assign hit[i]      = above_start & below_limit;

    // R5
    inverted_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_start[i] > win_limit[i]) |-> !hit[i]);
  end

  assign any_hit = |hit;
endmodule

// File: rtl/iwf_result.sv
module iwf_result (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  input  logic verdict_in,
  output logic res_valid,
  input  logic res_ready,
  output logic res_pass
);
  logic take;

  assign req_ready = !res_valid || res_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_pass  <= 1'b0;
    end else if (take) begin
      res_valid <= 1'b1;
      res_pass  <= verdict_in;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R7
  accept_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid);

  // R7
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && (!res_valid || res_ready)) |=> !res_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_pass)));
endmodule

// File: rtl/inbound_window_filter.sv
module inbound_window_filter #(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 2,
  parameter int CFG_AW  = $clog2(2 * NUM_WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_pass
);
  import iwf_pkg::*;

  logic [NUM_WIN-1:0][ADDR_W-1:0] win_start;
  logic [NUM_WIN-1:0][ADDR_W-1:0] win_limit;
  logic mode_excl;
  logic any_hit;
  logic pass_now;

  iwf_regs #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .win_start(win_start), .win_limit(win_limit),
    .mode_excl(mode_excl)
  );

  iwf_match #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) u_match (
    .clk(clk), .rst_n(rst_n), .addr(req_addr), .win_start(win_start),
    .win_limit(win_limit), .any_hit(any_hit)
  );

  assign pass_now = verdict(any_hit, mode_excl);

  iwf_result u_result (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .verdict_in(pass_now), .res_valid(res_valid), .res_ready(res_ready),
    .res_pass(res_pass)
  );

  // R8
  stall_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !req_ready);
endmodule

// File: tb/inbound_window_filter_bench.sv
module inbound_window_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_pass;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  inbound_window_filter u_inbound_window_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .res_valid(res_valid), .res_ready(res_ready),
    .res_pass(res_pass)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [31:0] a, input logic exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, {31'b0, res_valid}, 32'd1);
    chk({tag, " pass"}, {31'b0, res_pass}, {31'b0, exp});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 res_valid", {31'b0, res_valid}, 32'd0);
    chk("R1 req_ready", {31'b0, req_ready}, 32'd1);
    send(32'h0, 1'b0, "R1 addr0");
    send(32'hFFFF_FFFF, 1'b0, "R1 addrmax");
    send(32'h8000_0000, 1'b0, "R1 addrmid");
  endtask

  task automatic t_inclusive;
    wr(3'd0, 32'h0000_1000); wr(3'd1, 32'h0000_1FFF);
    send(32'h0000_0FFF, 1'b0, "R2 below start");
    send(32'h0000_1000, 1'b1, "R2 at start");
    send(32'h0000_1FFF, 1'b1, "R2 at limit");
    send(32'h0000_2000, 1'b0, "R3 above limit");
    wr(3'd2, 32'h0000_3003); wr(3'd3, 32'h0000_3005);
    send(32'h0000_3002, 1'b0, "R10 odd below");
    send(32'h0000_3003, 1'b1, "R10 odd start");
    send(32'h0000_3005, 1'b1, "R10 odd limit");
    send(32'h0000_3006, 1'b0, "R10 odd above");
    send(32'h0000_1800, 1'b1, "R10 win0 still");
  endtask

  task automatic t_exclusive;
    wr(3'd4, 32'h0000_0002);
    send(32'h0000_1500, 1'b0, "R4 inside win0");
    send(32'h0000_2500, 1'b1, "R4 outside");
    send(32'h0000_3004, 1'b0, "R4 inside win1");
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'h0000_0000);
    send(32'h0000_3004, 1'b1, "R5 win1 off excl");
    wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'h0000_0000);
    send(32'h0000_1500, 1'b1, "R5 both off excl");
    wr(3'd0, 32'h0000_1000); wr(3'd1, 32'h0000_1FFF);
  endtask

  task automatic t_inverted;
    wr(3'd4, 32'hFFFF_FFFD);
    send(32'h0000_1500, 1'b1, "R6 ctrl bit1 only");
    send(32'h0000_2500, 1'b0, "R6 ctrl bit1 only miss");
    wr(3'd2, 32'h0000_0010); wr(3'd3, 32'h0000_0005);
    send(32'h0000_0008, 1'b0, "R5 inverted incl");
    send(32'h0000_0010, 1'b0, "R5 inverted at start");
    wr(3'd5, 32'h0); wr(3'd6, 32'h0); wr(3'd7, 32'hFFFF_FFFF);
    send(32'h0000_1500, 1'b1, "R6 unmapped no effect");
    send(32'h0000_0008, 1'b0, "R6 unmapped win1 kept");
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h0000_1500; res_ready = 1'b0;
    @(negedge clk);
    chk("R8 first valid", {31'b0, res_valid}, 32'd1);
    chk("R8 first pass", {31'b0, res_pass}, 32'd1);
    req_addr = 32'h0000_2500;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 held valid", {31'b0, res_valid}, 32'd1);
      chk("R8 held pass", {31'b0, res_pass}, 32'd1);
      chk("R8 ready low", {31'b0, req_ready}, 32'd0);
    end
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 second valid", {31'b0, res_valid}, 32'd1);
    chk("R8 second pass", {31'b0, res_pass}, 32'd0);
    @(negedge clk);
    chk("R7 drains", {31'b0, res_valid}, 32'd0);
  endtask

  task automatic t_same_edge;
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 32'h2;
    req_valid = 1'b1; req_addr = 32'h0000_1500; res_ready = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R9 old settings", {31'b0, res_pass}, 32'd1);
    send(32'h0000_1500, 1'b0, "R9 new settings");
    wr(3'd4, 32'h0);
  endtask

  task automatic t_full_range;
    wr(3'd0, 32'h0); wr(3'd1, 32'hFFFF_FFFF);
    send(32'h0, 1'b1, "R2 full low");
    send(32'hFFFF_FFFF, 1'b1, "R2 full high");
    wr(3'd2, 32'h0); wr(3'd3, 32'hFFFF_FFFF);
    send(32'h8000_0000, 1'b1, "R10 overlap");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_inclusive();
    t_exclusive();
    t_inverted();
    t_backpressure();
    t_same_edge();
    t_full_range();
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule